// File: doc/BRIEF.md
# MII Receive Nibble Qualifier

This block sits behind the receive side of a media-independent interface. On every rising edge of the receive clock it samples a 4-bit nibble, a data-valid strobe and an error strobe from the PHY. It finds the start-of-frame delimiter, pairs the payload nibbles that follow into bytes, and hands the bytes downstream with strobes that mark the first byte, the last byte and a bad frame. The receive clock is 2.5 MHz at 10 Mbit/s and 25 MHz at 100 Mbit/s. The block runs off whichever clock it is given and has no rate setting.

At 100 Mbit/s the PHY raises data-valid together with the first preamble nibble. At 10 Mbit/s it raises data-valid together with the first delimiter nibble. The delimiter search copes with both cases. A mode pin selects terminal (DTE) or bridge (DCE) operation. In DTE mode a nibble that arrives with the error strobe high is dropped, and the frame is flagged as errored. In DCE mode the error strobe is ignored.

Each byte is held back until the next byte is complete, or until the frame ends, so that the end-of-frame strobe and the error result can ride on the last byte. Each output byte is a single-cycle pulse.

Top module: `mii_rx_qualifier`

## Requirements
- R1: After reset, and before any frame, `out_valid`, `out_sof`, `out_eof`, `out_err` and `out_dribble` are all 0.
- R2: A nibble sampled while `rx_dv` is 0 is never accepted. It produces no output byte and does not count toward delimiter detection. A 0x5, 0xD pattern sent with `rx_dv` low does not align a frame.
- R3: Once the delimiter is found, payload nibbles are paired in arrival order. `out_data[3:0]` is the first nibble of the pair and `out_data[7:4]` is the second.
- R4: The delimiter is an accepted nibble 0x5 immediately followed by an accepted nibble 0xD. It is found both when `rx_dv` rises on a run of 0x5 preamble nibbles and when `rx_dv` rises on the 0x5 delimiter nibble itself.
- R5: `out_sof` is 1 on the first byte of a frame only, and it always comes with `out_valid`.
- R6: A completed byte is presented with `out_valid` for exactly one cycle, on the edge that completes the following byte. The last byte of a frame is presented on the edge at which `rx_dv` is first sampled 0, and it carries `out_eof`=1.
- R7: In DTE mode (`mode_dce`=0), a nibble sampled with `rx_err`=1 is discarded. If `rx_err`=1 is sampled with `rx_dv`=1 at any point in a frame, the last byte carries `out_err`=1. `out_err` is 1 only together with `out_eof`.
- R8: In DCE mode (`mode_dce`=1), `rx_err` has no effect. Nibbles are accepted and no error is reported.
- R9: If `rx_dv` falls after an odd number of payload nibbles, the unpaired nibble is dropped. The last byte then carries `out_dribble`=1 and `out_err`=1.
- R10: A frame that ends before a complete payload byte produces no output strobes at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dce | input | 1 | 0: DTE, where the error strobe gates nibbles; 1: DCE, where the error strobe is ignored |
| rxd | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_err | input | 1 | Receive error strobe |
| out_data | output | 8 | Assembled byte, first nibble in the low half |
| out_valid | output | 1 | One-cycle byte strobe |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_err | output | 1 | Frame errored: error strobe seen or dribble nibble (valid with eof) |
| out_dribble | output | 1 | Frame ended on an unpaired nibble (valid with eof) |

## Verification
Frames are driven with long preambles, which is the 100 Mbit/s case, and with delimiter-only starts, which is the 10 Mbit/s case. Together these show that alignment does not depend on where data-valid rises. Idle gaps carry 0x5 and 0xD nibbles with data-valid low, which exposes any acceptance or alignment outside a frame. The same error-strobe frame is run in both DTE and DCE modes, which separates dropping and flagging from ignoring. Odd-length, zero-byte and one-byte frames probe the dribble path, the no-output path and the case where one byte carries both start and end. A behavioural model in the bench predicts every output strobe on every clock.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
   localparam int MII_NIB_W = 4;

   typedef enum logic {
      MODE_DTE = 1'b0,
      MODE_DCE = 1'b1
   } mii_mode_e;
endpackage

// File: rtl/mii_rx_sfd_hunt.sv
module mii_rx_sfd_hunt #(
   parameter int                NIB_W   = 4,
   parameter logic [NIB_W-1:0]  DELIM_A = 'h5,
   parameter logic [NIB_W-1:0]  DELIM_B = 'hD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dv,
   input  logic             take,
   input  logic [NIB_W-1:0] nib,
   output logic             in_frame
);
   logic saw_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saw_a    <= 1'b0;
         in_frame <= 1'b0;
      end else if (!dv) begin
         saw_a    <= 1'b0;
         in_frame <= 1'b0;
      end else if (take && !in_frame) begin
         in_frame <= saw_a && (nib == DELIM_B);
         saw_a    <= (nib == DELIM_A);
      end
   end
endmodule

// File: rtl/mii_rx_nibble_pack.sv
module mii_rx_nibble_pack #(
   parameter int NIB_W     = 4,
   parameter int NIBS      = 2,
   parameter bit LOW_FIRST = 1'b1,
   localparam int WORD_W   = NIB_W * NIBS,
   localparam int SLOT_W   = (NIBS > 1) ? $clog2(NIBS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [NIB_W-1:0]  nib,
   output logic              word_done,
   output logic [WORD_W-1:0] word,
   output logic              partial
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NIBS - 1);

   logic [SLOT_W-1:0] slot;
   logic [NIB_W-1:0]  hold [NIBS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  slot <= '0;
      else if (clear)              slot <= '0;
      else if (push) begin
         if (slot == LAST)         slot <= '0;
         else                      slot <= slot + 1'b1;
      end
   end

   assign hold[NIBS-1] = nib;

   for (genvar i = 0; i < NIBS - 1; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  hold[i] <= '0;
         else if (push && (slot == SLOT_W'(i)))       hold[i] <= nib;
      end
   end

   for (genvar i = 0; i < NIBS; i++) begin : g_word
      if (LOW_FIRST) begin : g_lo
         assign word[i*NIB_W +: NIB_W] = hold[i];
      end else begin : g_hi
         assign word[(NIBS-1-i)*NIB_W +: NIB_W] = hold[i];
      end
   end

   assign word_done = push && (slot == LAST);
   assign partial   = (slot != '0);
endmodule

// File: rtl/mii_rx_frame_out.sv
module mii_rx_frame_out #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv,
   input  logic              err_hit,
   input  logic              frame_end,
   input  logic              partial,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_err,
   output logic              out_dribble
);
   logic [WORD_W-1:0] pend;
   logic              pend_v;
   logic              pend_sof;
   logic              seen;
   logic              sticky;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_valid   <= 1'b0;
         out_sof     <= 1'b0;
         out_eof     <= 1'b0;
         out_err     <= 1'b0;
         out_dribble <= 1'b0;
         pend        <= '0;
         pend_v      <= 1'b0;
         pend_sof    <= 1'b0;
         seen        <= 1'b0;
      end else begin
         out_valid   <= 1'b0;
         out_sof     <= 1'b0;
         out_eof     <= 1'b0;
         out_err     <= 1'b0;
         out_dribble <= 1'b0;
         if (frame_end) begin
            if (pend_v) begin
               out_valid   <= 1'b1;
               out_data    <= pend;
               out_sof     <= pend_sof;
               out_eof     <= 1'b1;
               out_err     <= sticky | partial;
               out_dribble <= partial;
            end
            pend_v <= 1'b0;
            seen   <= 1'b0;
         end else if (word_done) begin
            if (pend_v) begin
               out_valid <= 1'b1;
               out_data  <= pend;
               out_sof   <= pend_sof;
            end
            pend     <= word;
            pend_v   <= 1'b1;
            pend_sof <= !seen;
            seen     <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sticky <= 1'b0;
      else if (!dv)     sticky <= 1'b0;
      else if (err_hit) sticky <= 1'b1;
   end
endmodule

// File: rtl/mii_rx_qualifier.sv
module mii_rx_qualifier
   import mii_rx_pkg::*;
#(
   parameter int               NIB_W     = MII_NIB_W,
   parameter int               NIBS      = 2,
   parameter bit               LOW_FIRST = 1'b1,
   parameter logic [NIB_W-1:0] DELIM_A   = 'h5,
   parameter logic [NIB_W-1:0] DELIM_B   = 'hD,
   localparam int              WORD_W    = NIB_W * NIBS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_dce,
   input  logic [NIB_W-1:0]  rxd,
   input  logic              rx_dv,
   input  logic              rx_err,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_err,
   output logic              out_dribble
);
   if (NIB_W != MII_NIB_W) begin : g_bad_nib
      $error("mii_rx_qualifier: NIB_W must equal the interface nibble width");
   end
   if (NIBS < 1) begin : g_bad_nibs
      $error("mii_rx_qualifier: NIBS must be at least 1");
   end

   logic err_gated;
   logic take;
   logic in_frame;
   logic push;
   logic word_done;
   logic partial;
   logic [WORD_W-1:0] word;

   assign err_gated = rx_err && (mii_mode_e'(mode_dce) == MODE_DTE);
   assign take      = rx_dv && !err_gated;
   assign push      = take && in_frame;

   mii_rx_sfd_hunt #(
      .NIB_W   (NIB_W),
      .DELIM_A (DELIM_A),
      .DELIM_B (DELIM_B)
   ) u_hunt (
      .clk      (clk),
      .rst_n    (rst_n),
      .dv       (rx_dv),
      .take     (take),
      .nib      (rxd),
      .in_frame (in_frame)
   );

   mii_rx_nibble_pack #(
      .NIB_W     (NIB_W),
      .NIBS      (NIBS),
      .LOW_FIRST (LOW_FIRST)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (!rx_dv),
      .push      (push),
      .nib       (rxd),
      .word_done (word_done),
      .word      (word),
      .partial   (partial)
   );

   mii_rx_frame_out #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .dv          (rx_dv),
      .err_hit     (rx_dv && err_gated),
      .frame_end   (in_frame && !rx_dv),
      .partial     (partial),
      .word_done   (word_done),
      .word        (word),
      .out_data    (out_data),
      .out_valid   (out_valid),
      .out_sof     (out_sof),
      .out_eof     (out_eof),
      .out_err     (out_err),
      .out_dribble (out_dribble)
   );
endmodule

// File: rtl/mii_rx_qualifier_chk.sv
module mii_rx_qualifier_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_dv,
   input logic out_valid,
   input logic out_sof,
   input logic out_eof,
   input logic out_err,
   input logic out_dribble
);
   // R5
   sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   // R6
   eof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> out_valid);

   // R7
   err_only_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_eof);

   // R9
   dribble_is_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_dribble |-> (out_eof && out_err));

   // R2
   quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rx_dv) && !$past(rx_dv, 2)) |-> !out_valid);

   // R6
   valid_single_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |=> !out_eof);
endmodule

bind mii_rx_qualifier mii_rx_qualifier_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_dv       (rx_dv),
   .out_valid   (out_valid),
   .out_sof     (out_sof),
   .out_eof     (out_eof),
   .out_err     (out_err),
   .out_dribble (out_dribble)
);

// File: tb/mii_rx_qualifier_tb.sv
`timescale 1ns/1ps
module mii_rx_qualifier_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_dce = 1'b0;
   logic [3:0] rxd = 4'h0;
   logic       rx_dv = 1'b0;
   logic       rx_err = 1'b0;
   logic [7:0] out_data;
   logic       out_valid, out_sof, out_eof, out_err, out_dribble;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   mii_rx_qualifier u_dut (
      .clk(clk), .rst_n(rst_n), .mode_dce(mode_dce), .rxd(rxd),
      .rx_dv(rx_dv), .rx_err(rx_err), .out_data(out_data),
      .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
      .out_err(out_err), .out_dribble(out_dribble)
   );

   // behavioural reference model state
   bit  m_aligned, m_last5, m_seen, m_bad;
   int  m_nibs[$];
   int  m_held[$];
   bit  m_held_sof;
   bit  e_valid, e_sof, e_eof, e_err, e_drib;
   int  e_data;
   int  eof_seen = 0, eof_expected = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, cur_req, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit eg;
      eg = rx_err && !mode_dce;
      e_valid = 0; e_sof = 0; e_eof = 0; e_err = 0; e_drib = 0;
      if (!rst_n) begin
         m_aligned = 0; m_last5 = 0; m_seen = 0; m_bad = 0;
         m_nibs.delete(); m_held.delete();
      end else if (!rx_dv) begin
         if (m_aligned && m_held.size() > 0) begin
            e_valid = 1; e_data = m_held.pop_front(); e_sof = m_held_sof;
            e_eof = 1; e_drib = (m_nibs.size() % 2) != 0; e_err = m_bad || e_drib;
            eof_expected++;
         end
         m_aligned = 0; m_last5 = 0; m_seen = 0; m_bad = 0;
         m_nibs.delete(); m_held.delete();
      end else begin
         if (eg) m_bad = 1;
         else if (!m_aligned) begin
            if (m_last5 && rxd == 4'hD) m_aligned = 1;
            m_last5 = (rxd == 4'h5);
         end else begin
            m_nibs.push_back(int'(rxd));
            if (m_nibs.size() == 2) begin
               int b;
               b = m_nibs[0] + 16 * m_nibs[1];
               m_nibs.delete();
               if (m_held.size() > 0) begin
                  e_valid = 1; e_data = m_held.pop_front(); e_sof = m_held_sof;
               end
               m_held.push_back(b);
               m_held_sof = !m_seen;
               m_seen = 1;
            end
         end
      end
      #5;
      if (rst_n) begin
         check("R6 valid", int'(out_valid), int'(e_valid));
         if (e_valid) begin
            check("R3 data", int'(out_data), e_data);
            check("R5 sof", int'(out_sof), int'(e_sof));
            check("R6 eof", int'(out_eof), int'(e_eof));
            check("R7 err", int'(out_err), int'(e_err));
            check("R9 dribble", int'(out_dribble), int'(e_drib));
         end
         if (out_valid && out_eof) eof_seen++;
      end
   end

   task automatic nib(input bit dv, input bit er, input int n);
      @(negedge clk);
      rx_dv = dv; rx_err = er; rxd = 4'(n);
   endtask

   // idle with 5/D garbage on the bus (R2)
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) nib(0, 0, (i % 2) ? 'hD : 'h5);
   endtask

   task automatic frame(input int npre, input int npay, input int err_at,
                        input bit dce, input int base);
      mode_dce = dce;
      for (int i = 0; i < npre; i++) nib(1, 0, 'h5);
      nib(1, 0, 'hD);
      for (int i = 0; i < npay; i++) nib(1, i == err_at, (base + 7 * i) & 15);
      idle(3);
   endtask

   initial begin
      idle(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1 valid", int'(out_valid), 0);
      check("R1 sof", int'(out_sof), 0);
      check("R1 eof", int'(out_eof), 0);
      check("R1 err", int'(out_err), 0);
      check("R1 dribble", int'(out_dribble), 0);

      cur_req = "R2"; idle(8);
      cur_req = "R4 long preamble"; frame(15, 12, -1, 0, 3);
      cur_req = "R4 delimiter start"; frame(1, 10, -1, 0, 9);
      cur_req = "R3 bytes"; frame(7, 20, -1, 0, 1);
      cur_req = "R7 DTE error"; frame(7, 12, 5, 0, 2);
      cur_req = "R8 DCE error ignored"; frame(7, 12, 5, 1, 2);
      cur_req = "R9 odd nibbles"; frame(3, 9, -1, 0, 4);
      cur_req = "R10 empty frame"; frame(3, 0, -1, 0, 0);
      cur_req = "R10 one nibble"; frame(1, 1, -1, 0, 0);
      cur_req = "R5 single byte"; frame(1, 2, -1, 0, 6);
      cur_req = "R2 no delimiter"; mode_dce = 0;
      for (int i = 0; i < 6; i++) nib(1, 0, 'h5);
      idle(4);
      cur_req = "R4 preamble error"; mode_dce = 0;
      nib(1, 0, 'h5); nib(1, 1, 'h3); nib(1, 0, 'hD);
      for (int i = 0; i < 6; i++) nib(1, 0, i);
      idle(3);
      cur_req = "R6 frame count";
      check("R6 eof count", eof_seen, eof_expected);
      check("R6 eof count nonzero", int'(eof_expected > 5), 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule